// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the address presented to a synchronous memory core during burst accesses. An external address is captured whenever either of two active-low address strobes is sampled low on a rising clock edge. One strobe serves a processor and the other serves a cache or memory controller. After the capture, an active-low advance input steps an internal two-bit beat counter. The low two address bits that leave the block follow the selected burst order. The upper bits stay exactly as captured.

Two burst orders are available. The order pin is active low for linear order and high for interleaved order. In linear order the low bits are the starting bits plus the beat count, modulo four. In interleaved order they are the starting bits XORed with the beat count. Bursting is optional. A strobe may arrive on every cycle, and each one loads a fresh address with no dead cycle. The output is registered, so a captured address or a step becomes visible on the cycle after the edge that sampled it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `addr_out` is all zeros.
- R2: If either `proc_strobe_n` or `ctrl_strobe_n` is low at a rising edge, `addr_out` equals the `addr_in` sampled at that edge from the next cycle on, and the beat count restarts at zero.
- R3: Both strobes low together behave exactly like a single strobe.
- R4: With `linear_n` low, each edge with `adv_n` low and both strobes high steps the low two bits of `addr_out` to (start + count) mod 4, where count is the number of advances since the load.
- R5: With `linear_n` high, the low two bits of `addr_out` are start XOR count.
- R6: An edge with both strobes high and `adv_n` high leaves `addr_out` unchanged, as long as `linear_n` is also unchanged.
- R7: A strobe and a low `adv_n` at the same edge load the new address, and the count goes to zero rather than stepping.
- R8: After four advances the count wraps, and the low bits return to the starting bits in both orders.
- R9: Between loads, bits above bit 1 of `addr_out` never change, including when the linear low bits roll from 3 to 0.
- R10: Strobes on consecutive edges load consecutive addresses, each visible one cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| linear_n | input | 1 | Burst order: low = linear, high = interleaved |
| addr_in | input | ADDR_W | External address captured on a strobe |
| addr_out | output | ADDR_W | Current address to the memory core |

## Verification
Two functions can land on the same rising edge: a strobe that reloads the address, and an advance that steps the beat counter. The bench provokes this collision in the middle of a burst, with both the processor strobe and the controller strobe, in both burst orders. A cycle-accurate reference model judges each case. The model requires that the new address appear with its low bits unchanged, which shows that the count went to zero instead of stepping. Random stimulus then overlaps strobes, advances and order changes, and the model is compared with the design on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } burst_cmd_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_pkg::*;
(
    input  logic       proc_strobe_n,
    input  logic       ctrl_strobe_n,
    input  logic       adv_n,
    output burst_cmd_e cmd
);
    // Either strobe outranks the advance request.
    always_comb begin
        if (!proc_strobe_n || !ctrl_strobe_n) begin
            cmd = CMD_LOAD;
        end else if (!adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end
endmodule

// File: rtl/burst_count_step.sv
module burst_count_step
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  burst_cmd_e        cmd,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_d
);
    always_comb begin
        unique case (cmd)
            CMD_LOAD: cnt_d = '0;
            CMD_STEP: cnt_d = CNT_W'(cnt_q + 1'b1);
            default:  cnt_d = cnt_q;
        endcase
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  burst_order_e      order,
    input  logic [CNT_W-1:0]  start_bits,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  low_bits
);
    logic [CNT_W-1:0] lin_bits;
    logic [CNT_W-1:0] ilv_bits;

    assign lin_bits = CNT_W'(start_bits + cnt);

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_bits[b] = start_bits[b] ^ cnt[b];
    end

    always_comb begin
        if (order == ORD_LINEAR) begin
            low_bits = lin_bits;
        end else begin
            low_bits = ilv_bits;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              linear_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int CNT_W = $clog2(BURST_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
    } burst_state_t;

    burst_state_t     st_d, st_q;
    burst_cmd_e       cmd;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] low_bits;
    burst_order_e     order;

    assign order = burst_order_e'(linear_n);

    burst_cmd_decode u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .cmd           (cmd)
    );

    burst_count_step #(.CNT_W(CNT_W)) u_step (
        .cmd   (cmd),
        .cnt_q (st_q.cnt),
        .cnt_d (cnt_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_next;
        if (cmd == CMD_LOAD) begin
            st_d.base = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .order      (order),
        .start_bits (st_q.base[CNT_W-1:0]),
        .cnt        (st_q.cnt),
        .low_bits   (low_bits)
    );

    assign addr_out = {st_q.base[ADDR_W-1:CNT_W], low_bits};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W    = 20,
    parameter int BURST_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              adv_n,
    input logic              linear_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    localparam int CNT_W = $clog2(BURST_LEN);

    logic strobe;
    assign strobe = !proc_strobe_n || !ctrl_strobe_n;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> addr_out == $past(addr_in));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && adv_n) |=> ($stable(linear_n) -> $stable(addr_out)));

    // R9
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(addr_out[ADDR_W-1:CNT_W]));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !adv_n && !linear_n) |=>
        (!linear_n -> addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .linear_n      (linear_n),
    .addr_in       (addr_in),
    .addr_out      (addr_out)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          linear_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) u_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n), .linear_n(linear_n),
        .addr_in(addr_in), .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] model_addr();
        int s;
        int low;
        s = int'(m_base[1:0]);
        if (!linear_n) low = (s + m_cnt) % 4;
        else           low = s ^ m_cnt;
        return {m_base[AW-1:2], 2'(low)};
    endfunction

    task automatic check(input logic [AW-1:0] exp, input string tag);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s addr_out=%h expected=%h", tag, addr_out, exp);
        end
    endtask

    // Drive one cycle, update the model at the edge, compare at the falling edge.
    task automatic cyc(input logic p, input logic c, input logic a,
                       input logic lin, input logic [AW-1:0] ad, input string tag);
        proc_strobe_n = p;
        ctrl_strobe_n = c;
        adv_n         = a;
        linear_n      = lin;
        addr_in       = ad;
        @(posedge clk);
        if (!p || !c) begin
            m_base = ad;
            m_cnt  = 0;
        end else if (!a) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        check(model_addr(), tag);
    endtask

    initial begin
        logic [AW-1:0] start;
        repeat (3) @(negedge clk);
        check('0, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check('0, "R1 after reset");

        // Linear burst from low bits 01, wrap after four advances.
        start = 20'h12345;
        cyc(0, 1, 1, 0, start, "R2 proc load");
        check(start, "R2 loaded value");
        cyc(1, 1, 0, 0, '0, "R4 linear beat1");
        check(20'h12346, "R4 linear 01->10");
        cyc(1, 1, 0, 0, '0, "R4 linear beat2");
        cyc(1, 1, 0, 0, '0, "R9 linear 11->00");
        check(20'h12344, "R9 no carry into upper bits");
        cyc(1, 1, 0, 0, '0, "R8 linear wrap");
        check(start, "R8 linear back to start");
        cyc(1, 1, 1, 0, '0, "R6 hold");
        cyc(1, 1, 1, 0, 20'hFFFFF, "R6 hold ignores addr_in");
        check(start, "R6 held value");

        // Interleaved burst from low bits 10.
        start = 20'hABCDE;
        cyc(1, 0, 1, 1, start, "R2 ctrl load");
        cyc(1, 1, 0, 1, '0, "R5 ilv beat1");
        check(20'hABCDF, "R5 10^01=11");
        cyc(1, 1, 0, 1, '0, "R5 ilv beat2");
        check(20'hABCDC, "R5 10^10=00");
        cyc(1, 1, 0, 1, '0, "R5 ilv beat3");
        cyc(1, 1, 0, 1, '0, "R8 ilv wrap");
        check(start, "R8 ilv back to start");

        // Strobe collides with advance.
        cyc(1, 1, 0, 1, '0, "R7 pre step");
        cyc(0, 1, 0, 1, 20'h00F0B, "R7 proc+adv ilv");
        check(20'h00F0B, "R7 count restarted");
        cyc(1, 1, 0, 0, '0, "R7 step linear");
        cyc(1, 0, 0, 0, 20'h55551, "R7 ctrl+adv linear");
        check(20'h55551, "R7 linear restart");

        cyc(0, 0, 1, 0, 20'h77772, "R3 both strobes");
        check(20'h77772, "R3 both strobes value");

        for (int i = 0; i < 6; i++) begin
            cyc((i % 2) == 0, (i % 2) != 0, 0, 1, AW'(32'h1000 + i * 7), "R10 back to back");
        end
        check(AW'(32'h1000 + 35), "R10 last load");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc(r[0] | r[1], r[1] | r[2], r[3], (i / 37) % 2 == 0, AW'($urandom), "R4 R5 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule